// File: doc/BRIEF.md
# CAN Controller Interrupt Status Logic

This block turns the raw conditions of a CAN-style bus controller into one 32-bit interrupt status word and a single interrupt line. Nine conditions feed it: receive FIFO holds data, transmit buffer released, error status, bus status, data overrun, error-passive state, arbitration lost, bus error and bus idle. Each status bit has its own trigger rule. It may follow a level, fire on a rising edge, fire on any change, or fire on entry to and exit from a state.

Every source has an enable bit in an enable word, at the same bit position as its status bit. An event is captured only when its enable is set at that moment. Captured events stay in the register until software reads it. The read strobe clears the sticky bits on the clock edge where it is sampled, unless a new event for that bit arrives in the same cycle.

The error-passive source is tracked by a two-state machine:
- State `ST_ACTIVE` moves to `ST_PASSIVE` through the transition *enter* when the passive input rises.
- State `ST_PASSIVE` moves back to `ST_ACTIVE` through the transition *leave* when the passive input falls.
- Either transition is an event.

All inputs are assumed to be synchronous to the clock. Edge and change detection compares each input with a copy of it registered one cycle earlier. The status word is registered, so an input applied before a clock edge is visible at the output after that edge.

Top module: `canirq_status`

## Requirements
- R1: Reset (active-low, asynchronous) clears the status word to 0. The status bits sit at these positions: receive 0, transmit 1, error warning 2, data overrun 3, error passive 5, arbitration lost 6, bus error 7, idle 8. Bit 4 and bits 9 to 31 always read 0, whatever the enable word holds.
- R2: The receive bit is a level. After each clock edge it equals the receive-not-empty input ANDed with enable bit 0, as both were sampled at that edge.
- R3: The transmit bit is set by a 0-to-1 transition of the transmit-released input while enable bit 1 is set. A level that stays high does not set it again.
- R4: The error warning bit is set by any change, rising or falling, of either the error status input or the bus status input while enable bit 2 is set.
- R5: The data overrun bit is set only by a 0-to-1 transition of the overrun input while enable bit 3 is set. A falling transition does not set it.
- R6: The error passive bit is set while enable bit 5 is set on both transitions: entering the passive state (input rises) and returning to the active state (input falls).
- R7: The arbitration lost input (enable bit 6) and the bus error input (enable bit 7) are event strobes. Every cycle in which the strobe is high and its enable is set, the bit is set.
- R8: The idle bit is set when the idle input rises while enable bit 8 is set. An idle level that stays high does not set it again.
- R9: All bits except receive stay set until a read. A read strobe sampled at a clock edge clears them on that edge. A read never clears the receive bit.
- R10: An event for a bit in the same cycle as a read takes priority, so that bit is 1 after the edge.
- R11: Enables act at capture. An event whose enable is clear is ignored. Clearing an enable does not clear a status bit that is already set.
- R12: The interrupt output is 1 exactly when any status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_nonempty_i | input | 1 | Receive FIFO holds at least one frame |
| tx_released_i | input | 1 | Transmit buffer released status |
| err_stat_i | input | 1 | Error status condition |
| bus_stat_i | input | 1 | Bus status condition |
| overrun_i | input | 1 | Data overrun status |
| err_passive_i | input | 1 | Node is in the error-passive state |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| bus_err_i | input | 1 | Bus error strobe |
| idle_i | input | 1 | Controller is idle |
| irq_en_i | input | 32 | Enable word, one bit per status bit position |
| rd_strobe_i | input | 1 | Status register read, clears sticky bits |
| status_o | output | 32 | Interrupt status word |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The checks that run on every cycle cover these properties:
- reserved bits held at zero;
- the receive bit tracking its gated level;
- rising transmit edges and bus error strobes being captured;
- sticky bits holding while no read is present;
- a read clearing the arbitration bit when no new event competes with it;
- the interrupt line matching the OR of the status word.

Only the bench's scenarios can show the following:
- the both-edge behaviour of the error warning and error passive sources;
- a falling overrun edge that does nothing;
- read and event colliding in the same cycle;
- enables removed after capture;
- a reset applied in the middle of a run.

// File: rtl/canirq_pkg.sv
package canirq_pkg;

    localparam int STAT_W = 32;

    localparam int POS_RX = 0;
    localparam int POS_TX = 1;
    localparam int POS_EW = 2;
    localparam int POS_OV = 3;
    localparam int POS_EP = 5;
    localparam int POS_AL = 6;
    localparam int POS_BE = 7;
    localparam int POS_ID = 8;

    typedef enum logic [1:0] {
        TRIG_RISE   = 2'd0,
        TRIG_ANY    = 2'd1,
        TRIG_STROBE = 2'd2
    } trig_mode_e;

    typedef enum logic {
        ST_ACTIVE  = 1'b0,
        ST_PASSIVE = 1'b1
    } ep_state_e;

    function automatic logic [STAT_W-1:0] bit_at(input int pos);
        logic [STAT_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    localparam logic [STAT_W-1:0] LEVEL_MASK  = bit_at(POS_RX);
    localparam logic [STAT_W-1:0] STICKY_MASK =
        bit_at(POS_TX) | bit_at(POS_EW) | bit_at(POS_OV) | bit_at(POS_EP) |
        bit_at(POS_AL) | bit_at(POS_BE) | bit_at(POS_ID);

endpackage

// File: rtl/canirq_trig.sv
module canirq_trig
    import canirq_pkg::*;
#(
    parameter int         WIDTH = 1,
    parameter trig_mode_e MODE  = TRIG_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic             hit
);

    generate
        if (MODE == TRIG_STROBE) begin : g_strobe
            assign hit = |sig;
        end else begin : g_edge
            logic [WIDTH-1:0] prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= sig;
            end

            if (MODE == TRIG_ANY) begin : g_any
                assign hit = |(sig ^ prev_q);
            end else begin : g_rise
                assign hit = |(sig & ~prev_q);
            end
        end
    endgenerate

endmodule

// File: rtl/canirq_ep_fsm.sv
module canirq_ep_fsm
    import canirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic passive_i,
    output logic flip_o
);

    ep_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (passive_i)  state_d = ST_PASSIVE;
            ST_PASSIVE: if (!passive_i) state_d = ST_ACTIVE;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        flip_o = 1'b0;
        unique case (state_q)
            ST_ACTIVE:  flip_o = passive_i;
            ST_PASSIVE: flip_o = !passive_i;
            default:    flip_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/canirq_stat_reg.sv
module canirq_stat_reg #(
    parameter int             W           = 32,
    parameter logic [W-1:0]   LEVEL_BITS  = '0,
    parameter logic [W-1:0]   STICKY_BITS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] lvl,
    input  logic         rd,
    output logic [W-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (LEVEL_BITS[i]) begin : g_level
                logic bit_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) bit_q <= 1'b0;
                    else        bit_q <= lvl[i];
                end
                assign q[i] = bit_q;
            end else if (STICKY_BITS[i]) begin : g_sticky
                logic bit_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) bit_q <= 1'b0;
                    else        bit_q <= set_ev[i] | (bit_q & ~rd);
                end
                assign q[i] = bit_q;
            end else begin : g_zero
                assign q[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/canirq_status.sv
module canirq_status
    import canirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_nonempty_i,
    input  logic              tx_released_i,
    input  logic              err_stat_i,
    input  logic              bus_stat_i,
    input  logic              overrun_i,
    input  logic              err_passive_i,
    input  logic              arb_lost_i,
    input  logic              bus_err_i,
    input  logic              idle_i,
    input  logic [STAT_W-1:0] irq_en_i,
    input  logic              rd_strobe_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic tx_hit, ew_hit, ov_hit, ep_hit, al_hit, be_hit, id_hit;
    logic [STAT_W-1:0] raw_ev, raw_lvl;

    canirq_trig #(.WIDTH(1), .MODE(TRIG_RISE)) u_tx (
        .clk(clk), .rst_n(rst_n), .sig(tx_released_i), .hit(tx_hit));

    canirq_trig #(.WIDTH(2), .MODE(TRIG_ANY)) u_ew (
        .clk(clk), .rst_n(rst_n), .sig({bus_stat_i, err_stat_i}), .hit(ew_hit));

    canirq_trig #(.WIDTH(1), .MODE(TRIG_RISE)) u_ov (
        .clk(clk), .rst_n(rst_n), .sig(overrun_i), .hit(ov_hit));

    canirq_trig #(.WIDTH(1), .MODE(TRIG_STROBE)) u_al (
        .clk(clk), .rst_n(rst_n), .sig(arb_lost_i), .hit(al_hit));

    canirq_trig #(.WIDTH(1), .MODE(TRIG_STROBE)) u_be (
        .clk(clk), .rst_n(rst_n), .sig(bus_err_i), .hit(be_hit));

    canirq_trig #(.WIDTH(1), .MODE(TRIG_RISE)) u_id (
        .clk(clk), .rst_n(rst_n), .sig(idle_i), .hit(id_hit));

    canirq_ep_fsm u_ep (
        .clk(clk), .rst_n(rst_n), .passive_i(err_passive_i), .flip_o(ep_hit));

    always_comb begin
        raw_ev          = '0;
        raw_ev[POS_TX]  = tx_hit;
        raw_ev[POS_EW]  = ew_hit;
        raw_ev[POS_OV]  = ov_hit;
        raw_ev[POS_EP]  = ep_hit;
        raw_ev[POS_AL]  = al_hit;
        raw_ev[POS_BE]  = be_hit;
        raw_ev[POS_ID]  = id_hit;
        raw_lvl         = '0;
        raw_lvl[POS_RX] = rx_nonempty_i;
    end

    canirq_stat_reg #(
        .W(STAT_W), .LEVEL_BITS(LEVEL_MASK), .STICKY_BITS(STICKY_MASK)
    ) u_reg (
        .clk(clk), .rst_n(rst_n),
        .set_ev(raw_ev & irq_en_i),
        .lvl(raw_lvl & irq_en_i),
        .rd(rd_strobe_i),
        .q(status_o)
    );

    assign irq_o = |status_o;

endmodule

// File: rtl/canirq_status_chk.sv
module canirq_status_chk
    import canirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_nonempty_i,
    input logic              tx_released_i,
    input logic              arb_lost_i,
    input logic              bus_err_i,
    input logic [STAT_W-1:0] irq_en_i,
    input logic              rd_strobe_i,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o
);

    logic pv_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~(LEVEL_MASK | STICKY_MASK)) == '0);

    a_r2_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q |-> status_o[POS_RX] == ($past(rx_nonempty_i) & $past(irq_en_i[POS_RX])));

    a_r3_tx_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && tx_released_i && !$past(tx_released_i) && irq_en_i[POS_TX])
        |=> status_o[POS_TX]);

    a_r7_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_i && irq_en_i[POS_BE]) |=> status_o[POS_BE]);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && !rd_strobe_i)
        |=> (($past(status_o) & STICKY_MASK & ~status_o) == '0));

    a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && !(arb_lost_i && irq_en_i[POS_AL])) |=> !status_o[POS_AL]);

    a_r12_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_o != '0));

endmodule

bind canirq_status canirq_status_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .rx_nonempty_i(rx_nonempty_i), .tx_released_i(tx_released_i),
    .arb_lost_i(arb_lost_i), .bus_err_i(bus_err_i),
    .irq_en_i(irq_en_i), .rd_strobe_i(rd_strobe_i),
    .status_o(status_o), .irq_o(irq_o)
);

// File: tb/canirq_status_test.sv
module canirq_status_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  ins = '0;
    logic [31:0] en = '0;
    logic        rd = 1'b0;
    logic [31:0] status;
    logic        irq;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    canirq_status uut (
        .clk(clk), .rst_n(rst_n),
        .rx_nonempty_i(ins[0]), .tx_released_i(ins[1]),
        .err_stat_i(ins[2]), .bus_stat_i(ins[3]),
        .overrun_i(ins[4]), .err_passive_i(ins[5]),
        .arb_lost_i(ins[6]), .bus_err_i(ins[7]), .idle_i(ins[8]),
        .irq_en_i(en), .rd_strobe_i(rd),
        .status_o(status), .irq_o(irq)
    );

    // Row layout: {rd, inputs[8:0], enable, expected status, requirement}
    // inputs: 0 rx, 1 tx, 2 err, 3 bus, 4 overrun, 5 passive, 6 arb, 7 buserr, 8 idle
    localparam int NV = 31;
    localparam logic [77:0] VEC [0:NV-1] = '{
        {1'b0, 9'h001, 32'h1EF, 32'h001, 4'd2},   // R2 level
        {1'b0, 9'h003, 32'h1EF, 32'h003, 4'd3},   // R3 rise
        {1'b0, 9'h003, 32'h1EF, 32'h003, 4'd9},   // R9 held
        {1'b1, 9'h003, 32'h1EF, 32'h001, 4'd9},   // R9 read keeps rx
        {1'b0, 9'h000, 32'h1EF, 32'h000, 4'd2},
        {1'b0, 9'h004, 32'h1EF, 32'h004, 4'd4},   // R4 rise
        {1'b1, 9'h004, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h000, 32'h1EF, 32'h004, 4'd4},   // R4 fall
        {1'b1, 9'h008, 32'h1EF, 32'h004, 4'd10},  // R10 collide
        {1'b1, 9'h008, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h018, 32'h1EF, 32'h008, 4'd5},   // R5 rise
        {1'b1, 9'h018, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h008, 32'h1EF, 32'h000, 4'd5},   // R5 fall ignored
        {1'b0, 9'h028, 32'h1EF, 32'h020, 4'd6},   // R6 enter
        {1'b1, 9'h028, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h008, 32'h1EF, 32'h020, 4'd6},   // R6 leave
        {1'b1, 9'h008, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h048, 32'h1EF, 32'h040, 4'd7},   // R7 arb
        {1'b0, 9'h048, 32'h1EF, 32'h040, 4'd7},
        {1'b1, 9'h008, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h088, 32'h1EF, 32'h080, 4'd7},   // R7 bus error
        {1'b1, 9'h088, 32'h1EF, 32'h080, 4'd10},  // R10 strobe wins
        {1'b1, 9'h008, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h108, 32'h1EF, 32'h100, 4'd8},   // R8 rise
        {1'b1, 9'h108, 32'h1EF, 32'h000, 4'd9},
        {1'b0, 9'h108, 32'h1EF, 32'h000, 4'd8},   // R8 no retrigger
        {1'b0, 9'h00A, 32'h1ED, 32'h000, 4'd11},  // R11 disabled tx
        {1'b0, 9'h009, 32'h1EE, 32'h000, 4'd11},  // R11 disabled rx
        {1'b0, 9'h049, 32'h1EF, 32'h041, 4'd7},
        {1'b0, 9'h009, 32'h000, 32'h040, 4'd11},  // R11 enable removed
        {1'b1, 9'h009, 32'h000, 32'h000, 4'd9}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL R0 watchdog actual=%h expected=%h", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status, 32'h0, 1);                 // R1 reset state
        check({31'h0, irq}, 32'h0, 12);          // R12
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {rd, ins, en} = VEC[k][77:36];
            @(negedge clk);
            check(status, VEC[k][35:4], int'(VEC[k][3:0]));
            check({31'h0, irq}, {31'h0, VEC[k][35:4] != 0}, 12);   // R12
        end
        // R1: reserved bits stay zero with every enable bit set
        rd  = 1'b0;
        en  = 32'hFFFF_FFFF;
        ins = 9'h1F6;
        @(negedge clk);
        check(status & ~32'h1EF, 32'h0, 1);
        check(status, 32'h1EE, 1);
        // R1: reset in the middle of a run clears everything
        rst_n = 1'b0;
        ins   = '0;
        @(negedge clk);
        check(status, 32'h0, 1);
        check({31'h0, irq}, 32'h0, 12);
        rst_n = 1'b1;
        @(negedge clk);
        check(status, 32'h0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule